// File: doc/BRIEF.md
# DRAM refresh and initialisation scheduler

This block sits beside the access sequencer of an asynchronous DRAM controller and decides when refresh cycles must run. After a synchronous reset it holds off all traffic for a fixed settling time. It then demands a fixed number of warm-up refresh cycles. Once those are done it raises `init_done` and switches to periodic operation. In periodic operation one refresh falls due every retention period divided by the row count, and that interval is converted to clock cycles from the clock frequency parameter.

The sequencer takes refresh work through a request/acknowledge pair. Deadlines that the sequencer cannot serve at once are kept in a bounded backlog. The request stays high until the backlog is empty, and a backlog deeper than one entry is flagged as urgent. A mode input picks the refresh style. In the CAS-before-RAS style the memory keeps its own row counter, so no address is needed. In the RAS-only style the block supplies the row from its own counter, which steps once per served refresh. A row-size input picks the smaller array or the one with twice as many rows; the extra high address bit is non-zero only in the larger option.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, `rfsh_req` and `init_done` stay low for exactly CLK_MHZ*SETTLE_US clock edges, and `rfsh_req` is high after the next edge.
- R2: During warm-up, `rfsh_req` stays high until WARMUP acknowledgements have been accepted. `init_done` rises on the edge that accepts the last one, and it then stays high until reset.
- R3: In periodic operation a refresh falls due every floor(CLK_MHZ*RETAIN_US / rows) edges, counted from the edge that ends warm-up. Here rows is 2^ROW_BITS_LO with `rows_large`=0 and 2^(ROW_BITS_LO+1) with `rows_large`=1.
- R4: Each due refresh adds one to a backlog, and each accepted acknowledgement (`rfsh_ack` high while `rfsh_req` is high) removes one. `rfsh_req` is high exactly while the backlog is non-zero, and it never drops without an acknowledgement.
- R5: The backlog saturates at PEND_MAX; deadlines that arrive while it is full are dropped.
- R6: `rfsh_urgent` is high exactly when the backlog holds two or more refreshes, and it is never high without `rfsh_req`.
- R7: `rfsh_kind` gives the style of the requested refresh: 1 for RAS-only (it follows `ras_only_mode`=1) and 0 for CAS-before-RAS.
- R8: `rfsh_row` starts at 0 after reset. It advances by one on each accepted acknowledgement in RAS-only mode and holds its value for an acknowledgement in CAS-before-RAS mode.
- R9: `rfsh_row` wraps to 0 after rows-1 (2^ROW_BITS_LO or 2^(ROW_BITS_LO+1), as in R3); its top bit can only be set with `rows_large`=1.
- R10: `rfsh_ack` while `rfsh_req` is low changes neither the backlog nor `rfsh_row`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rows_large | input | 1 | 1 selects the doubled row count |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh, 0 CAS-before-RAS |
| rfsh_ack | input | 1 | The sequencer takes the pending refresh |
| rfsh_req | output | 1 | A refresh is owed |
| rfsh_urgent | output | 1 | More than one refresh is owed |
| rfsh_kind | output | 1 | Refresh style of the request (1 RAS-only) |
| rfsh_row | output | ROW_BITS_LO+1 | Row for a RAS-only refresh |
| init_done | output | 1 | Settling and warm-up are complete |

## Verification
The properties assume that reset is applied before the first useful cycle. They also assume that `rows_large` and `ras_only_mode` are quasi-static, changing only while no acknowledgement is being given, so a row step is always judged against the mode in force at that edge. The stimulus meets these assumptions: it changes the configuration only in cycles where `rfsh_ack` is low. It asserts `rfsh_ack` while a request is pending, except in two deliberate cases that probe the rule on ignored acknowledgements: once during settling and once in an idle gap of periodic operation. The backlog is driven to saturation by withholding acknowledgements for more deadlines than it can hold.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    // Sequencing phases of the scheduler
    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_WARM   = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

    // Request bundle presented to the access sequencer
    typedef struct packed {
        logic req;
        logic urgent;
        logic kind;   // 1: RAS-only, 0: CAS-before-RAS
    } rfsh_cmd_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles between refresh deadlines: retention / rows, in clock cycles
    function automatic int unsigned interval_cycles(input int unsigned clk_mhz,
                                                    input int unsigned retain_us,
                                                    input int unsigned row_bits);
        return (clk_mhz * retain_us) >> row_bits;
    endfunction

endpackage

// File: rtl/rfsh_phase_seq.sv
module rfsh_phase_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 25000,
    parameter int unsigned WARMUP     = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   grant,
    output phase_e phase,
    output logic   init_done
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int WW = $clog2(WARMUP + 1);

    phase_e        phase_q;
    logic [SW-1:0] settle_q;
    logic [WW-1:0] warm_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_SETTLE;
            settle_q <= '0;
            warm_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_SETTLE: begin
                    if (settle_q == SW'(SETTLE_CYC - 1))
                        phase_q <= PH_WARM;
                    else
                        settle_q <= settle_q + 1'b1;
                end
                PH_WARM: begin
                    if (grant) begin
                        if (warm_q == WW'(WARMUP - 1)) begin
                            phase_q <= PH_RUN;
                            done_q  <= 1'b1;
                        end else begin
                            warm_q <= warm_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase     = phase_q;
    assign init_done = done_q;

endmodule

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned INTV_SMALL = 1953,
    parameter int unsigned INTV_LARGE = 976
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic rows_large,
    output logic tick
);
    localparam int unsigned INTV_MAX = umax(INTV_SMALL, INTV_LARGE);
    localparam int CW = $clog2(INTV_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          hit;

    // A shortened limit after a row-size change is caught by >=
    assign limit = rows_large ? CW'(INTV_LARGE - 1) : CW'(INTV_SMALL - 1);
    assign hit   = run && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (hit)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = hit;

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int unsigned PEND_MAX = 8,
    localparam int PW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          grant,
    output logic          busy,
    output logic          urgent,
    output logic [PW-1:0] level
);
    logic [PW-1:0] cnt_q;
    logic          dec;

    assign dec = grant && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick && !dec) begin
            if (cnt_q != PW'(PEND_MAX))
                cnt_q <= cnt_q + 1'b1;
        end else if (dec && !tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy   = (cnt_q != '0);
    assign urgent = (cnt_q > PW'(1));
    assign level  = cnt_q;

endmodule

// File: rtl/rfsh_rowgen.sv
module rfsh_rowgen #(
    parameter int unsigned ROW_BITS_LO = 12,
    localparam int RW = ROW_BITS_LO + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          rows_large,
    output logic [RW-1:0] row
);
    localparam logic [RW-1:0] MASK_SMALL = RW'((64'd1 << ROW_BITS_LO) - 64'd1);

    logic [RW-1:0] row_q;
    logic [RW-1:0] mask;

    assign mask = rows_large ? {RW{1'b1}} : MASK_SMALL;

    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (step)
            row_q <= (row_q + 1'b1) & mask;
    end

    assign row = row_q;

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 125,
    parameter int unsigned SETTLE_US   = 200,
    parameter int unsigned RETAIN_US   = 64000,
    parameter int unsigned WARMUP      = 8,
    parameter int unsigned PEND_MAX    = 8,
    parameter int unsigned ROW_BITS_LO = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rows_large,
    input  logic                 ras_only_mode,
    input  logic                 rfsh_ack,
    output logic                 rfsh_req,
    output logic                 rfsh_urgent,
    output logic                 rfsh_kind,
    output logic [ROW_BITS_LO:0] rfsh_row,
    output logic                 init_done
);
    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int unsigned INTV_SMALL = interval_cycles(CLK_MHZ, RETAIN_US, ROW_BITS_LO);
    localparam int unsigned INTV_LARGE = interval_cycles(CLK_MHZ, RETAIN_US, ROW_BITS_LO + 1);
    localparam int PW = $clog2(PEND_MAX + 1);

    phase_e        phase;
    logic          grant;
    logic          tick;
    logic          backlog_busy;
    logic          backlog_urgent;
    logic [PW-1:0] pend_cnt;
    rfsh_cmd_t     cmd;

    rfsh_phase_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .WARMUP     (WARMUP)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .phase     (phase),
        .init_done (init_done)
    );

    rfsh_tick_gen #(
        .INTV_SMALL (INTV_SMALL),
        .INTV_LARGE (INTV_LARGE)
    ) u_tick (
        .clk        (clk),
        .rst        (rst),
        .run        (phase == PH_RUN),
        .rows_large (rows_large),
        .tick       (tick)
    );

    rfsh_backlog #(
        .PEND_MAX (PEND_MAX)
    ) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .grant  (grant),
        .busy   (backlog_busy),
        .urgent (backlog_urgent),
        .level  (pend_cnt)
    );

    rfsh_rowgen #(
        .ROW_BITS_LO (ROW_BITS_LO)
    ) u_row (
        .clk        (clk),
        .rst        (rst),
        .step       (grant && ras_only_mode),
        .rows_large (rows_large),
        .row        (rfsh_row)
    );

    always_comb begin
        cmd.req    = (phase == PH_WARM) || backlog_busy;
        cmd.urgent = backlog_urgent;
        cmd.kind   = ras_only_mode;
    end

    assign grant       = rfsh_ack && cmd.req;
    assign rfsh_req    = cmd.req;
    assign rfsh_urgent = cmd.urgent;
    assign rfsh_kind   = cmd.kind;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int unsigned PEND_MAX    = 8,
    parameter int unsigned ROW_BITS_LO = 12,
    localparam int PW = $clog2(PEND_MAX + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ras_only_mode,
    input logic                 rfsh_ack,
    input logic                 rfsh_req,
    input logic                 rfsh_urgent,
    input logic [ROW_BITS_LO:0] rfsh_row,
    input logic                 init_done,
    input logic [PW-1:0]        pend_cnt
);

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done)
        else $error("init_done fell after warm-up");

    assert_init_on_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(rfsh_req && rfsh_ack))
        else $error("init_done rose without an accepted refresh");

    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && !rfsh_ack) |=> rfsh_req)
        else $error("request dropped without acknowledgement");

    assert_urgent_has_req_R6: assert property (@(posedge clk) disable iff (rst)
        rfsh_urgent |-> rfsh_req)
        else $error("urgent without request");

    assert_cbr_row_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rfsh_ack && rfsh_req && !ras_only_mode) |=> $stable(rfsh_row))
        else $error("row moved on a CAS-before-RAS refresh");

    assert_idle_ack_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (rfsh_ack && !rfsh_req) |=> $stable(rfsh_row))
        else $error("row moved on an ignored acknowledgement");

    always @(posedge clk) begin
        if (!rst) begin
            assert_no_overflow_R5: assert (pend_cnt <= PW'(PEND_MAX))
                else $error("backlog above its limit");
        end
    end

endmodule

bind rfsh_sched rfsh_sched_chk #(
    .PEND_MAX    (PEND_MAX),
    .ROW_BITS_LO (ROW_BITS_LO)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ras_only_mode (ras_only_mode),
    .rfsh_ack      (rfsh_ack),
    .rfsh_req      (rfsh_req),
    .rfsh_urgent   (rfsh_urgent),
    .rfsh_row      (rfsh_row),
    .init_done     (init_done),
    .pend_cnt      (pend_cnt)
);

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;
    localparam int unsigned CLK_MHZ_P  = 1;
    localparam int unsigned SETTLE_P   = 50;
    localparam int unsigned RETAIN_P   = 160;
    localparam int unsigned WARMUP_P   = 8;
    localparam int unsigned PEND_P     = 8;
    localparam int unsigned LO_P       = 3;
    localparam int unsigned SETTLE_CYC = CLK_MHZ_P * SETTLE_P;   // 50
    localparam int unsigned INTV_S     = (CLK_MHZ_P * RETAIN_P) >> LO_P;        // 20
    localparam int unsigned INTV_L     = (CLK_MHZ_P * RETAIN_P) >> (LO_P + 1);  // 10

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rows_large = 1'b0;
    logic          ras_only_mode = 1'b1;
    logic          rfsh_ack = 1'b0;
    logic          rfsh_req;
    logic          rfsh_urgent;
    logic          rfsh_kind;
    logic [LO_P:0] rfsh_row;
    logic          init_done;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_row = 0;
    logic [LO_P:0] q_row[$];
    logic          q_kind[$];

    always #4 clk = ~clk;   // 125 MHz

    rfsh_sched #(
        .CLK_MHZ     (CLK_MHZ_P),
        .SETTLE_US   (SETTLE_P),
        .RETAIN_US   (RETAIN_P),
        .WARMUP      (WARMUP_P),
        .PEND_MAX    (PEND_P),
        .ROW_BITS_LO (LO_P)
    ) u_rfsh_sched (
        .clk           (clk),
        .rst           (rst),
        .rows_large    (rows_large),
        .ras_only_mode (ras_only_mode),
        .rfsh_ack      (rfsh_ack),
        .rfsh_req      (rfsh_req),
        .rfsh_urgent   (rfsh_urgent),
        .rfsh_kind     (rfsh_kind),
        .rfsh_row      (rfsh_row),
        .init_done     (init_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Driver: one accepted refresh; pushes the expected row and kind
    task automatic ack_one();
        q_row.push_back((LO_P + 1)'(exp_row));
        q_kind.push_back(ras_only_mode);
        @(negedge clk) rfsh_ack = 1'b1;
        @(posedge clk) #1 rfsh_ack = 1'b0;
        if (ras_only_mode)
            exp_row = (exp_row + 1) % (rows_large ? (2 << LO_P) : (1 << LO_P));
    endtask

    task automatic wait_req();
        int w = 0;
        while (!rfsh_req && w < 100) begin
            @(posedge clk) #1;
            w++;
        end
    endtask

    // Monitor: compares every accepted refresh against the scoreboard
    always @(negedge clk) begin
        #3;
        if (rfsh_ack && rfsh_req) begin
            if (q_row.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R8 unexpected grant: actual row %0d expected none", rfsh_row);
            end else begin
                chk("R8/R9 row at grant", int'(rfsh_row), int'(q_row.pop_front()));
                chk("R7 kind at grant", int'(rfsh_kind), int'(q_kind.pop_front()));
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int x_edges;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset req", int'(rfsh_req), 0);
        chk("R1 reset init_done", int'(init_done), 0);
        chk("R8 reset row", int'(rfsh_row), 0);
        chk("R6 reset urgent", int'(rfsh_urgent), 0);
        rst = 1'b0;
        rfsh_ack = 1'b1;                      // R10 ack while idle in settling
        repeat (3) @(posedge clk);
        #1 rfsh_ack = 1'b0;
        repeat (SETTLE_CYC - 4) @(posedge clk);
        #1 chk("R1 req low at last settle edge", int'(rfsh_req), 0);
        @(posedge clk) #1;
        chk("R1 req after settle", int'(rfsh_req), 1);
        chk("R2 init_done low before warm-up", int'(init_done), 0);
        chk("R10 row after idle ack", int'(rfsh_row), 0);

        // Warm-up in RAS-only mode, small rows: rows 0..7 then wrap
        for (int i = 0; i < int'(WARMUP_P) - 1; i++) ack_one();
        chk("R2 req held during warm-up", int'(rfsh_req), 1);
        chk("R2 init_done before last warm-up", int'(init_done), 0);
        ack_one();
        chk("R2 init_done after warm-up", int'(init_done), 1);
        chk("R2 req low after warm-up", int'(rfsh_req), 0);
        chk("R9 row wrap at 8", int'(rfsh_row), 0);

        // First periodic deadline
        repeat (INTV_S - 1) @(posedge clk);
        #1 chk("R3 no request before interval", int'(rfsh_req), 0);
        @(posedge clk) #1;
        chk("R3 request at interval", int'(rfsh_req), 1);
        chk("R6 single backlog not urgent", int'(rfsh_urgent), 0);

        // Backlog build-up without acknowledgement, CAS-before-RAS mode
        ras_only_mode = 1'b0;
        repeat (INTV_S) @(posedge clk);
        #1 chk("R6 urgent at backlog two", int'(rfsh_urgent), 1);
        x_edges = INTV_S * 8;
        repeat (x_edges) @(posedge clk);
        #1 chk("R6 urgent at saturation", int'(rfsh_urgent), 1);
        for (int i = 0; i < int'(PEND_P) - 1; i++) ack_one();
        chk("R4 req with one left", int'(rfsh_req), 1);
        chk("R6 urgent clears at one left", int'(rfsh_urgent), 0);
        ack_one();
        chk("R5 backlog drained after PEND_MAX grants", int'(rfsh_req), 0);
        chk("R8 row held in CAS-before-RAS", int'(rfsh_row), 0);

        // Ignored acknowledgement in an idle gap, then large rows
        ras_only_mode = 1'b1;
        rows_large = 1'b1;
        @(negedge clk) rfsh_ack = 1'b1;
        @(posedge clk) #1 rfsh_ack = 1'b0;
        chk("R10 req unchanged by idle ack", int'(rfsh_req), 0);
        chk("R10 row unchanged by idle ack", int'(rfsh_row), 0);
        wait_req();
        chk("R4 request after idle ack", int'(rfsh_req), 1);

        // Interval in large-row mode
        ack_one();
        x_edges = 1;
        while (!rfsh_req && x_edges < 100) begin
            @(posedge clk) #1;
            x_edges++;
        end
        chk("R3 large-row interval", x_edges, int'(INTV_L));

        // RAS-only rows through the 16-row space
        for (int i = 1; i < 16; i++) begin
            wait_req();
            ack_one();
            if (i == 7) chk("R9 top row bit used in large mode", int'(rfsh_row), 8);
        end
        chk("R9 row wrap at 16", int'(rfsh_row), 0);

        repeat (4) @(posedge clk);
        chk("R8 scoreboard drained", q_row.size(), 0);
        summary();
        $finish;
    end

endmodule